// File: doc/BRIEF.md
# Oversampled Serial Receiver with Multidrop Address Filter

This block turns an asynchronous NRZ serial line into parallel characters. It watches a single receive input that rests at logic high. It finds each low start bit, samples the data bits at their centres and checks the stop bit. Timing comes from an enable pulse that a shared baud generator supplies at sixteen times the bit rate. Each character carries 8 or 9 data bits, chosen by a mode input, and the bits arrive least significant first.

Finished characters go into a two-entry queue. The host sees the oldest entry at the read outputs and removes it with a one-cycle pop. Each entry holds its data byte, its ninth bit and its own framing-error flag. A character that arrives with no free slot raises a sticky overrun flag. The host clears that flag with a one-cycle pulse.

On a 9-bit multidrop bus, address filtering can be switched on. In that mode the queue accepts only characters whose ninth bit is high, so data traffic meant for other nodes never reaches the host. An idle output shows whether a frame is currently being received.

Top module: `uart_addr_rx`

## Requirements
- R1: A low level on the synchronised line while idle is confirmed 8 oversample ticks later. If the line is high at that point, the receiver goes back to idle and stores nothing.
- R2: In 8-bit mode (`nine_bit_en`=0), the 8 bits after the start bit are stored least significant bit first in `rd_data[7:0]`, and `rd_bit9` reads 0.
- R3: In 9-bit mode, the ninth received bit is passed unchanged on `rd_bit9`, and no parity check is made.
- R4: If the stop bit is sampled low, the character is still stored, and its entry shows `rd_frame_err`=1. A high stop bit gives `rd_frame_err`=0.
- R5: The queue holds up to two characters in arrival order. `rd_valid` is high while it is non-empty, and `pop` removes the oldest entry.
- R6: If a character completes while both slots are full and `pop` is low in that cycle, `overrun` is set and the character is discarded. The buffered characters remain readable.
- R7: While `overrun` is high, every new character is discarded. A one-cycle `ovr_clear` drops the flag, and characters are accepted again afterwards.
- R8: With `nine_bit_en`=1 and `addr_det_en`=1, only characters whose ninth bit is 1 are stored. In 8-bit mode, `addr_det_en` has no effect.
- R9: `rx_idle` is low from start-bit detection until the stop bit has been sampled, and high otherwise.
- R10: If a character completes while the queue is full and `pop` is high in that same cycle, the character is stored and `overrun` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_16x | input | 1 | One-cycle enable at 16 times the bit rate |
| rx_line | input | 1 | Asynchronous serial input, idles high |
| nine_bit_en | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| addr_det_en | input | 1 | Store only characters with the ninth bit set (9-bit mode) |
| pop | input | 1 | Remove the oldest queued character |
| ovr_clear | input | 1 | Clear the overrun flag |
| rd_valid | output | 1 | Queue holds at least one character |
| rd_data | output | 8 | Data of the oldest character |
| rd_bit9 | output | 1 | Ninth bit of the oldest character |
| rd_frame_err | output | 1 | Framing error of the oldest character |
| overrun | output | 1 | Sticky overrun flag |
| rx_idle | output | 1 | No frame in progress |

## Verification
The completion of a character can land in the same cycle as a host pop. When the queue is full, that cycle decides between storing the character and raising overrun.

The bench first fills both slots. It then sends a third frame and waits for `rx_idle` to rise, which marks the completion cycle. It drives `pop` in exactly that cycle. The run passes if `overrun` stays low and the queue then yields the second and third characters in order. A separate case sends the third frame with no pop and requires the overrun flag and the discard.

// File: rtl/uart_addr_rx_pkg.sv
// Package: shared state encoding for the serial receiver.
// Assumes: one receiver state machine per instance.
package uart_addr_rx_pkg;
    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_t;
endpackage

// File: rtl/uart_addr_rx_sync.sv
// Module: multi-flop synchroniser for the asynchronous serial input.
// Assumes: the input idles high, so the flops reset to 1 to avoid a false start.
module uart_addr_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic d_sync
);
    logic [STAGES-1:0] pipe;

    // Shift the raw input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[STAGES-2:0], d_async};
    end

    assign d_sync = pipe[STAGES-1];
endmodule

// File: rtl/uart_addr_rx_framer.sv
// Module: bit-level receive state machine.
// Finds the start bit, samples the data bits at mid-bit, checks the stop bit
// and gives a one-cycle done pulse with the assembled character.
// Assumes: tick is a single-cycle enable at OSR times the bit rate, and
// rx_s is already synchronised. The character width is latched at start.
module uart_addr_rx_framer
    import uart_addr_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx_s,
    input  logic              nine_bit_en,
    output logic              done,
    output logic [DATA_W-1:0] char_data,
    output logic              char_bit9,
    output logic              char_ferr,
    output logic              idle
);
    localparam int SH_W  = DATA_W + 1;
    localparam int CNT_W = $clog2(OSR);
    localparam int IDX_W = $clog2(DATA_W + 2);
    localparam int HALF  = OSR / 2;

    rx_state_t          state;
    logic [CNT_W-1:0]   cnt;
    logic [IDX_W-1:0]   idx;
    logic [SH_W-1:0]    shreg;
    logic               nine_q;
    logic [IDX_W-1:0]   last_idx;

    assign last_idx = nine_q ? IDX_W'(DATA_W) : IDX_W'(DATA_W - 1);

    // Advance the frame state machine on each oversample tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= RX_IDLE;
            cnt       <= '0;
            idx       <= '0;
            shreg     <= '0;
            nine_q    <= 1'b0;
            done      <= 1'b0;
            char_ferr <= 1'b0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                case (state)
                    RX_IDLE: begin
                        if (!rx_s) begin
                            state  <= RX_START;
                            cnt    <= '0;
                            nine_q <= nine_bit_en;
                        end
                    end
                    RX_START: begin
                        if (cnt == CNT_W'(HALF - 1)) begin
                            if (rx_s) begin
                                state <= RX_IDLE;
                            end else begin
                                state <= RX_DATA;
                                cnt   <= '0;
                                idx   <= '0;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (cnt == CNT_W'(OSR - 1)) begin
                            cnt   <= '0;
                            shreg <= {rx_s, shreg[SH_W-1:1]};
                            if (idx == last_idx) state <= RX_STOP;
                            else                 idx   <= idx + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (cnt == CNT_W'(OSR - 1)) begin
                            state     <= RX_IDLE;
                            done      <= 1'b1;
                            char_ferr <= !rx_s;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end

    // Pick the data bits and the ninth bit out of the shift register.
    always_comb begin
        if (nine_q) begin
            char_data = shreg[DATA_W-1:0];
            char_bit9 = shreg[DATA_W];
        end else begin
            char_data = shreg[DATA_W:1];
            char_bit9 = 1'b0;
        end
    end

    assign idle = (state == RX_IDLE);
endmodule

// File: rtl/uart_addr_rx_fifo.sv
// Module: small circular receive queue with a show-ahead read port.
// Assumes: the caller never pushes when full unless it pops in the same cycle.
// A pop on an empty queue is ignored.
module uart_addr_rx_fifo #(
    parameter int W     = 10,
    parameter int DEPTH = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               wdata,
    input  logic                       pop,
    output logic [W-1:0]               rdata,
    output logic                       empty,
    output logic                       full,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic             do_pop;

    assign empty  = (count == '0);
    assign full   = (count == CNT_W'(DEPTH));
    assign do_pop = pop && !empty;
    assign rdata  = mem[rptr];

    // Update pointers and occupancy on push and pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push)   wptr <= (wptr == PTR_W'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (do_pop) rptr <= (rptr == PTR_W'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            if (push && !do_pop)      count <= count + 1'b1;
            else if (!push && do_pop) count <= count - 1'b1;
        end
    end

    // Write the storage slots; the contents need no reset.
    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (push && wptr == PTR_W'(g)) mem[g] <= wdata;
            end
        end
    endgenerate
endmodule

// File: rtl/uart_addr_rx.sv
// Module: top of the serial receiver with multidrop address filtering.
// Joins the synchroniser, the framer and the queue, and applies the address
// filter and the overrun policy.
// Assumes: the mode inputs do not change during a frame.
module uart_addr_rx #(
    parameter int DATA_W      = 8,
    parameter int OSR         = 16,
    parameter int DEPTH       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_16x,
    input  logic              rx_line,
    input  logic              nine_bit_en,
    input  logic              addr_det_en,
    input  logic              pop,
    input  logic              ovr_clear,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_bit9,
    output logic              rd_frame_err,
    output logic              overrun,
    output logic              rx_idle
);
    localparam int ENT_W = DATA_W + 2;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic              rx_s;
    logic              done;
    logic [DATA_W-1:0] char_data;
    logic              char_bit9;
    logic              char_ferr;
    logic              passes;
    logic              push;
    logic              push_bit9;
    logic              new_ovr;
    logic              empty;
    logic              full;
    logic [CNT_W-1:0]  fill_cnt;
    logic [ENT_W-1:0]  head;

    uart_addr_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (rx_line),
        .d_sync  (rx_s)
    );

    uart_addr_rx_framer #(.DATA_W(DATA_W), .OSR(OSR)) u_framer (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick_16x),
        .rx_s        (rx_s),
        .nine_bit_en (nine_bit_en),
        .done        (done),
        .char_data   (char_data),
        .char_bit9   (char_bit9),
        .char_ferr   (char_ferr),
        .idle        (rx_idle)
    );

    // Decide whether a finished character is stored, dropped or overruns.
    always_comb begin
        passes    = !(nine_bit_en && addr_det_en) || char_bit9;
        push      = done && passes && !overrun && (!full || pop);
        new_ovr   = done && passes && !overrun && full && !pop;
        push_bit9 = char_bit9;
    end

    uart_addr_rx_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .wdata ({char_ferr, char_bit9, char_data}),
        .pop   (pop),
        .rdata (head),
        .empty (empty),
        .full  (full),
        .count (fill_cnt)
    );

    // Keep the overrun flag set until the host clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) overrun <= 1'b0;
        else        overrun <= (overrun && !ovr_clear) || new_ovr;
    end

    assign rd_valid     = !empty;
    assign rd_data      = head[DATA_W-1:0];
    assign rd_bit9      = head[DATA_W];
    assign rd_frame_err = head[DATA_W+1];
endmodule

// File: rtl/uart_addr_rx_chk.sv
// Module: property checker for the serial receiver, attached by bind.
// Assumes: the signal names of the top module as connected below.
module uart_addr_rx_chk #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 2,
    parameter int CNT_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_s,
    input logic              rx_idle,
    input logic              overrun,
    input logic              ovr_clear,
    input logic              full,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic              pop,
    input logic              push,
    input logic              push_bit9,
    input logic              nine_bit_en,
    input logic              addr_det_en,
    input logic [CNT_W-1:0]  fill_cnt
);
    // R9
    idle_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_idle) |-> !$past(rx_s));

    // R6
    ovr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(full));

    // R7
    ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !ovr_clear) |=> overrun);

    // R5
    head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !pop) |=> (rd_valid && $stable(rd_data)));

    // R5
    depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fill_cnt) <= DEPTH);

    // R8
    addr_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && nine_bit_en && addr_det_en) |-> push_bit9);
endmodule

bind uart_addr_rx uart_addr_rx_chk #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .CNT_W  ($clog2(DEPTH + 1))
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_s        (rx_s),
    .rx_idle     (rx_idle),
    .overrun     (overrun),
    .ovr_clear   (ovr_clear),
    .full        (full),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .pop         (pop),
    .push        (push),
    .push_bit9   (push_bit9),
    .nine_bit_en (nine_bit_en),
    .addr_det_en (addr_det_en),
    .fill_cnt    (fill_cnt)
);

// File: tb/uart_addr_rx_bench.sv
// Bench: sweeps character values through the receiver and checks the queue,
// the flags and the idle output against values computed here.
module uart_addr_rx_bench;
    localparam int BIT = 32;   // 16 ticks, one tick every 2 cycles

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_16x = 1'b0;
    logic       rx_line = 1'b1;
    logic       nine_bit_en = 1'b0;
    logic       addr_det_en = 1'b0;
    logic       pop = 1'b0;
    logic       ovr_clear = 1'b0;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic       rd_bit9;
    logic       rd_frame_err;
    logic       overrun;
    logic       rx_idle;

    int vectors = 0;
    int miscompares = 0;

    uart_addr_rx u_uart_addr_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_16x     (tick_16x),
        .rx_line      (rx_line),
        .nine_bit_en  (nine_bit_en),
        .addr_det_en  (addr_det_en),
        .pop          (pop),
        .ovr_clear    (ovr_clear),
        .rd_valid     (rd_valid),
        .rd_data      (rd_data),
        .rd_bit9      (rd_bit9),
        .rd_frame_err (rd_frame_err),
        .overrun      (overrun),
        .rx_idle      (rx_idle)
    );

    always #4 clk = ~clk;
    always @(negedge clk) tick_16x <= ~tick_16x;

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic send(input int value, input int nbits, input bit stop_lvl);
        @(negedge clk);
        rx_line = 1'b0;
        repeat (BIT) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            rx_line = value[i];
            repeat (BIT / 2) @(negedge clk);
            if (i == 2) check("R9 busy mid-frame", rx_idle, 0);
            repeat (BIT - BIT / 2) @(negedge clk);
        end
        rx_line = stop_lvl;
        repeat (BIT) @(negedge clk);
        rx_line = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic do_pop();
        @(negedge clk);
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
    endtask

    task automatic expect_head(input string tag, input int data, input int b9, input int fe);
        check({tag, " valid"}, rd_valid, 1);
        check({tag, " data"}, rd_data, data);
        check({tag, " bit9"}, rd_bit9, b9);
        check({tag, " ferr"}, rd_frame_err, fe);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        check("R5 reset rd_valid", rd_valid, 0);
        check("R6 reset overrun", overrun, 0);
        check("R9 reset rx_idle", rx_idle, 1);

        // R2: full 8-bit sweep, LSB first
        for (int v = 0; v < 256; v++) begin
            send(v, 8, 1'b1);
            expect_head("R2 8-bit", v, 0, 0);
            do_pop();
        end
        check("R5 empty after sweep", rd_valid, 0);

        // R3: 9-bit mode, ninth bit passed through
        nine_bit_en = 1'b1;
        for (int i = 0; i < 32; i++) begin
            int v = (i * 37 + 5) % 512;
            send(v, 9, 1'b1);
            expect_head("R3 9-bit", v % 256, v / 256, 0);
            do_pop();
        end

        // R8: address filter keeps only ninth-bit-set characters
        addr_det_en = 1'b1;
        for (int i = 0; i < 32; i++) begin
            int b9 = (i ^ (i >> 2)) & 1;
            int v  = b9 * 256 + ((i * 29) % 256);
            send(v, 9, 1'b1);
            check("R8 filter valid", rd_valid, b9);
            if (b9 == 1) begin
                expect_head("R8 address", v % 256, 1, 0);
                do_pop();
            end
        end
        // R8: no effect in 8-bit mode
        nine_bit_en = 1'b0;
        send(8'h3C, 8, 1'b1);
        expect_head("R8 8-bit ignores filter", 8'h3C, 0, 0);
        do_pop();
        addr_det_en = 1'b0;

        // R4: low stop bit flags a framing error; R1: the trailing low is a false start
        send(8'h5A, 8, 1'b0);
        repeat (2 * BIT) @(negedge clk);
        expect_head("R4 framing", 8'h5A, 0, 1);
        do_pop();
        check("R1 no char from false start", rd_valid, 0);
        check("R1 idle after false start", rx_idle, 1);

        // R1: short glitch rejected
        rx_line = 1'b0;
        repeat (6) @(negedge clk);
        rx_line = 1'b1;
        repeat (2 * BIT) @(negedge clk);
        check("R1 glitch idle", rx_idle, 1);
        check("R1 glitch nothing stored", rd_valid, 0);

        // R6, R7: overrun and discard policy
        send(8'h11, 8, 1'b1);
        send(8'h22, 8, 1'b1);
        check("R5 two held no overrun", overrun, 0);
        send(8'h33, 8, 1'b1);
        check("R6 overrun set", overrun, 1);
        send(8'h44, 8, 1'b1);
        check("R7 overrun held", overrun, 1);
        expect_head("R6 first kept", 8'h11, 0, 0);
        do_pop();
        expect_head("R6 second kept", 8'h22, 0, 0);
        do_pop();
        check("R7 extras discarded", rd_valid, 0);
        send(8'h55, 8, 1'b1);
        check("R7 discard while set", rd_valid, 0);
        @(negedge clk);
        ovr_clear = 1'b1;
        @(negedge clk);
        ovr_clear = 1'b0;
        check("R7 cleared", overrun, 0);
        send(8'h66, 8, 1'b1);
        expect_head("R7 accepted after clear", 8'h66, 0, 0);
        do_pop();

        // R10: pop in the completion cycle while full
        send(8'hA1, 8, 1'b1);
        send(8'hB2, 8, 1'b1);
        fork
            send(8'hC3, 8, 1'b1);
            begin
                @(posedge rx_idle);
                @(negedge clk);
                pop = 1'b1;
                @(negedge clk);
                pop = 1'b0;
            end
        join
        check("R10 no overrun", overrun, 0);
        expect_head("R10 second", 8'hB2, 0, 0);
        do_pop();
        expect_head("R10 third", 8'hC3, 0, 0);
        do_pop();
        check("R10 drained", rd_valid, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule